// File: doc/BRIEF.md
# DMA Bus Hold Arbiter with Ready Stall

This block lets a DMA controller that asks for the bus with a plain hold/acknowledge pair take the system bus from a CPU that has no usable hold input. The arbiter watches the CPU's bus-cycle status. It accepts a hold request only while the CPU is idle or on the last clock of a bus cycle. When it accepts, it acknowledges the DMA controller. In the same clock it pulls the CPU's ready line low and turns off the CPU's bus drivers. The CPU then waits in wait states, cut off from the bus, while the DMA controller makes one short single transfer. When the DMA controller drops its request, the arbiter hands the bus back in two steps: it turns the CPU drivers on first and raises ready one clock later.

A refresh timer is built in. It raises a DMA request for the DRAM refresh channel on a fixed period, derived from the clock frequency parameter, and holds that request until the refresh channel's acknowledge arrives. A watchdog raises an error output if the DMA controller keeps the bus longer than its six-clock single-transfer allowance.

Top module: `dma_hold_arbiter`

## Requirements
- R1: A hold request is accepted only in a clock where `cpu_busy` is low or `cpu_cyc_end` is high. While `cpu_busy` is high and `cpu_cyc_end` is low, `dma_hlda` stays low.
- R2: When a request is accepted, all three outputs change on the next clock edge: `dma_hlda` goes high, `cpu_ready` goes low and `cpu_bus_en` goes low.
- R3: While a request waits for an acceptance point, `cpu_ready` stays high, so the CPU cycle in progress completes. While `dma_hlda` is high, `cpu_ready` stays low.
- R4: On the edge after `dma_hold` is seen low during a grant, `dma_hlda` goes low and `cpu_bus_en` goes high, with `cpu_ready` still low. `cpu_ready` goes high on the following edge.
- R5: `refresh_dreq` rises exactly P clocks after reset is released, and every P clocks after that. P = CLK_MHZ * REFRESH_NS / 1000, which is 2600 with the default values.
- R6: `refresh_dreq` stays high until `refresh_dack` is sampled high. It is low after that edge.
- R7: `hold_err` is high while `dma_hlda` is high, `dma_hold` is high, and the grant has lasted HOLD_LIMIT (6) full clocks, that is, from the 7th granted clock on. It is low otherwise.
- R8: After a synchronous reset, `dma_hlda` is 0, `cpu_ready` is 1, `cpu_bus_en` is 1, `refresh_dreq` is 0 and `hold_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_busy | input | 1 | CPU bus cycle in progress |
| cpu_cyc_end | input | 1 | Last clock of the current CPU bus cycle |
| dma_hold | input | 1 | Bus request from the DMA controller |
| dma_hlda | output | 1 | Bus grant to the DMA controller |
| cpu_ready | output | 1 | Ready to the CPU; low inserts wait states |
| cpu_bus_en | output | 1 | Enable for the CPU bus drivers |
| refresh_dreq | output | 1 | DMA request on the refresh channel |
| refresh_dack | input | 1 | DMA acknowledge for the refresh channel |
| hold_err | output | 1 | The DMA controller has held the bus too long |

## Verification
The acceptance logic is driven with every useful mix of idle, mid-cycle and end-of-cycle status, each with and without a request. This separates a grant taken at a legal point from one taken in the middle of a cycle, and from one taken when nothing was requested. A request kept pending across several mid-cycle clocks shows that ready is not pulled early. A normal six-clock transfer and an overlong one show whether the watchdog triggers at the right edge. The refresh timer is measured from reset and between requests, with the acknowledge delayed, to confirm both the period and that the request is held until acknowledged.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    ST_CPU     = 2'd0,
    ST_DMA     = 2'd1,
    ST_HANDOFF = 2'd2
  } own_state_t;

  // Clocks per refresh interval for a clock in MHz and a period in ns.
  function automatic int refresh_period(input int clk_mhz, input int period_ns);
    return (clk_mhz * period_ns) / 1000;
  endfunction

  // Legal grant point: CPU idle or on its final bus-cycle clock.
  function automatic logic grant_point(input logic busy, input logic cyc_end);
    return !busy || cyc_end;
  endfunction

endpackage

// File: rtl/hold_fsm.sv
module hold_fsm
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cpu_busy,
  input  logic cpu_cyc_end,
  input  logic dma_hold,
  output logic dma_hlda,
  output logic cpu_ready,
  output logic cpu_bus_en
);

  own_state_t state_q, state_d;
  logic       take_bus;
  logic       give_back;

  assign take_bus  = dma_hold && grant_point(cpu_busy, cpu_cyc_end);
  assign give_back = !dma_hold;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_CPU:     if (take_bus)  state_d = ST_DMA;
      ST_DMA:     if (give_back) state_d = ST_HANDOFF;
      ST_HANDOFF:                state_d = ST_CPU;
      default:                   state_d = ST_CPU;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_CPU;
    else     state_q <= state_d;
  end

  assign dma_hlda   = (state_q == ST_DMA);
  assign cpu_bus_en = (state_q != ST_DMA);
  assign cpu_ready  = (state_q == ST_CPU);

  p_no_midcycle_grant_r1: assert property (@(posedge clk) disable iff (rst)
    (!dma_hlda && cpu_busy && !cpu_cyc_end) |=> !dma_hlda);

  p_grant_isolates_r2: assert property (@(posedge clk) disable iff (rst)
    dma_hlda |-> (!cpu_ready && !cpu_bus_en));

  p_release_order_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(dma_hlda) |-> (cpu_bus_en && !cpu_ready) ##1 cpu_ready);

endmodule

// File: rtl/refresh_gen.sv
module refresh_gen
  import arb_pkg::*;
#(
  parameter int CLK_MHZ    = 200,
  parameter int REFRESH_NS = 13000
) (
  input  logic clk,
  input  logic rst,
  input  logic refresh_dack,
  output logic refresh_dreq
);

  localparam int PERIOD = refresh_period(CLK_MHZ, REFRESH_NS);
  localparam int CW     = $clog2(PERIOD);

  logic [CW-1:0] cnt_q;
  logic          tick;
  logic          dreq_q;

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= CW'(PERIOD - 1);
      dreq_q <= 1'b0;
    end else begin
      cnt_q <= tick ? CW'(PERIOD - 1) : cnt_q - 1'b1;
      if (tick)              dreq_q <= 1'b1;
      else if (refresh_dack) dreq_q <= 1'b0;
    end
  end

  assign refresh_dreq = dreq_q;

  p_dreq_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (refresh_dreq && !refresh_dack) |=> refresh_dreq);

  p_dack_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (refresh_dack && !tick) |=> !refresh_dreq);

endmodule

// File: rtl/hold_watchdog.sv
module hold_watchdog #(
  parameter int HOLD_LIMIT = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic dma_hlda,
  input  logic dma_hold,
  output logic hold_err
);

  localparam int WW = $clog2(HOLD_LIMIT + 1) + 1;

  logic [WW-1:0] span_q;
  logic          span_full;

  assign span_full = (span_q >= WW'(HOLD_LIMIT));

  always_ff @(posedge clk) begin
    if (rst)              span_q <= '0;
    else if (!dma_hlda)   span_q <= '0;
    else if (!span_full)  span_q <= span_q + 1'b1;
  end

  assign hold_err = dma_hlda && dma_hold && span_full;

  p_err_when_granted_r7: assert property (@(posedge clk) disable iff (rst)
    hold_err |-> (dma_hlda && dma_hold));

endmodule

// File: rtl/dma_hold_arbiter.sv
module dma_hold_arbiter #(
  parameter int CLK_MHZ    = 200,
  parameter int REFRESH_NS = 13000,
  parameter int HOLD_LIMIT = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic cpu_busy,
  input  logic cpu_cyc_end,
  input  logic dma_hold,
  output logic dma_hlda,
  output logic cpu_ready,
  output logic cpu_bus_en,
  output logic refresh_dreq,
  input  logic refresh_dack,
  output logic hold_err
);

  logic grant_w;

  hold_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .cpu_busy    (cpu_busy),
    .cpu_cyc_end (cpu_cyc_end),
    .dma_hold    (dma_hold),
    .dma_hlda    (grant_w),
    .cpu_ready   (cpu_ready),
    .cpu_bus_en  (cpu_bus_en)
  );

  refresh_gen #(
    .CLK_MHZ    (CLK_MHZ),
    .REFRESH_NS (REFRESH_NS)
  ) u_refresh (
    .clk          (clk),
    .rst          (rst),
    .refresh_dack (refresh_dack),
    .refresh_dreq (refresh_dreq)
  );

  hold_watchdog #(
    .HOLD_LIMIT (HOLD_LIMIT)
  ) u_wdog (
    .clk      (clk),
    .rst      (rst),
    .dma_hlda (grant_w),
    .dma_hold (dma_hold),
    .hold_err (hold_err)
  );

  assign dma_hlda = grant_w;

  p_ready_low_in_grant_r3: assert property (@(posedge clk) disable iff (rst)
    dma_hlda |-> !cpu_ready);

endmodule

// File: tb/dma_hold_arbiter_bench.sv
`timescale 1ns/1ps
module dma_hold_arbiter_bench;

  localparam int P = (200 * 13000) / 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_busy = 1'b0, cpu_cyc_end = 1'b0, dma_hold = 1'b0, refresh_dack = 1'b0;
  logic dma_hlda, cpu_ready, cpu_bus_en, refresh_dreq, hold_err;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dma_hold_arbiter u_dma_hold_arbiter (
    .clk(clk), .rst(rst), .cpu_busy(cpu_busy), .cpu_cyc_end(cpu_cyc_end),
    .dma_hold(dma_hold), .dma_hlda(dma_hlda), .cpu_ready(cpu_ready),
    .cpu_bus_en(cpu_bus_en), .refresh_dreq(refresh_dreq),
    .refresh_dack(refresh_dack), .hold_err(hold_err)
  );

  // {busy, cyc_end, hold, expected grant}
  localparam logic [3:0] VEC [6] = '{
    4'b0011, 4'b1010, 4'b1111, 4'b0000, 4'b1100, 4'b0111
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; cpu_busy = 0; cpu_cyc_end = 0; dma_hold = 0; refresh_dack = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    @(negedge clk);
    do_reset();
    // R8 reset state
    chk("R8 hlda", dma_hlda, 1'b0);
    chk("R8 ready", cpu_ready, 1'b1);
    chk("R8 bus_en", cpu_bus_en, 1'b1);
    chk("R8 dreq", refresh_dreq, 1'b0);
    chk("R8 err", hold_err, 1'b0);

    // R1/R2 acceptance table
    for (int i = 0; i < 6; i++) begin
      cpu_busy = VEC[i][3]; cpu_cyc_end = VEC[i][2]; dma_hold = VEC[i][1];
      @(negedge clk);
      chk("R1 grant point", dma_hlda, VEC[i][0]);
      if (VEC[i][0]) begin
        chk("R2 ready low", cpu_ready, 1'b0);
        chk("R2 bus off", cpu_bus_en, 1'b0);
      end
      cpu_busy = 0; cpu_cyc_end = 0; dma_hold = 0;
      repeat (3) @(negedge clk);
    end

    // R3 pending request during a long CPU cycle
    cpu_busy = 1; dma_hold = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R3 no early stall", cpu_ready, 1'b1);
      chk("R1 no midcycle grant", dma_hlda, 1'b0);
    end
    cpu_cyc_end = 1;
    @(negedge clk);
    cpu_busy = 0; cpu_cyc_end = 0;
    chk("R2 grant at end", dma_hlda, 1'b1);
    // normal six-clock transfer
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R3 ready held low", cpu_ready, 1'b0);
      chk("R7 no err in allowance", hold_err, 1'b0);
    end
    dma_hold = 0;
    chk("R7 no err after drop", hold_err, 1'b0);
    @(negedge clk);
    chk("R4 hlda off", dma_hlda, 1'b0);
    chk("R4 bus on first", cpu_bus_en, 1'b1);
    chk("R4 ready still low", cpu_ready, 1'b0);
    @(negedge clk);
    chk("R4 ready back", cpu_ready, 1'b1);

    // R7 overlong hold
    dma_hold = 1;
    @(negedge clk);
    chk("R2 idle grant", dma_hlda, 1'b1);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk("R7 err early", hold_err, 1'b0);
    end
    @(negedge clk);
    chk("R7 err on 7th clock", hold_err, 1'b1);
    @(negedge clk);
    chk("R7 err persists", hold_err, 1'b1);
    dma_hold = 0;
    #0.1;
    chk("R7 err clears with hold", hold_err, 1'b0);
    repeat (3) @(negedge clk);

    // R5/R6 refresh timing
    do_reset();
    n = 0;
    while (!refresh_dreq && n < P + 10) begin
      @(negedge clk); n++;
    end
    chk("R5 first period", (n == P), 1'b1);
    if (n != P) $display("FAIL R5: got %0d expected %0d", n, P);
    n = 0;
    repeat (4) begin
      @(negedge clk); n++;
      chk("R6 held without dack", refresh_dreq, 1'b1);
    end
    refresh_dack = 1;
    @(negedge clk); n++;
    refresh_dack = 0;
    chk("R6 cleared by dack", refresh_dreq, 1'b0);
    while (!refresh_dreq && n < P + 10) begin
      @(negedge clk); n++;
    end
    chk("R5 repeat period", (n == P), 1'b1);
    if (n != P) $display("FAIL R5: got %0d expected %0d", n, P);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule